// File: doc/BRIEF.md
# Transport-Triggered Move Datapath

This block is the execution core of a processor with no opcodes. Every instruction word is a bundle of data moves, one slot per transport bus. Each slot names a source endpoint and a destination endpoint. An endpoint is a general register, a port of the ALU function unit, or, for sources only, a literal carried in the slot itself. Arithmetic and logic happen only as a side effect: a move that lands on one of the ALU's trigger addresses starts the operation that address stands for. The operation works on the latched operand value and the value just written. The answer appears on the ALU result port, and later moves copy it into the register file.

Instructions arrive on a valid/ready port and one instruction runs per accepted cycle. All buses carry their moves in that same cycle. Every slot's source is read from the state before the instruction, and only then are the destinations written. The value each bus carries is visible on an output, and so is the ALU result port.

Top module: `move_datapath`

## Requirements
- R1: While reset is asserted and on its release, all eight 16-bit registers, the ALU operand latch and the ALU result are zero, and `instr_ready_o` is low. From the first clock edge after release, `instr_ready_o` is high.
- R2: Slot layout (bus 0 in the lowest bits): bit 26 valid, bits 25:21 source, bits 20:16 destination, bits 15:0 literal. Endpoint codes 0..7 are registers r0..r7, 8 is the ALU operand latch, 9 is the ALU result and 10 is the slot literal (source only). A move into a register is read back unchanged by a later move from that register.
- R3: A write to the operand latch (code 8) only stores the value. It neither starts an operation nor changes the result port.
- R4: Destination codes 16 to 21 are trigger addresses for ADD, SUB, AND, OR, XOR and NAND, in that order. A write there computes operand-latch OP written-value; SUB is operand minus written value.
- R5: The result of a trigger move accepted in cycle k can be read by a move accepted in cycle k+2. A move accepted in cycle k+1 reads the previous result.
- R6: The operand latch keeps its value across any number of triggers. When one instruction writes both the latch and a trigger, the operation uses the newly written latch value.
- R7: Both bus slots of one instruction execute in the same cycle, and each bus output shows the value its move carries.
- R8: All sources of an instruction are read before any destination is written, so two moves in one instruction swap two registers.
- R9: When both buses write the same destination in one instruction, the bus 1 value is kept.
- R10: A slot with its valid bit clear, or any slot while `instr_valid_i` is low, writes nothing, reports its bus idle and drives zero on its bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present |
| instr_ready_o | output | 1 | Datapath accepts an instruction this cycle |
| instr_i | input | 54 | Instruction word, two 27-bit move slots |
| bus_busy_o | output | 2 | Per bus, a move executes this cycle |
| bus_data_o | output | 32 | Per bus, the 16-bit value carried (bus 0 low) |
| fu_result_o | output | 16 | Current ALU result port value |

## Verification
The bench reads the result port exactly one cycle after a trigger. A design with too little latency would already show the new value there, and one with too much would miss it a cycle later. A register swap inside one instruction exposes a design that writes before reading, because one register would come back holding the other's old value twice. A same-register write conflict between buses catches a wrong priority order. A combined operand-plus-trigger instruction gives 3 - 5 = 0xFFFE only if the fresh latch value is used, so a stale operand shows up as a different number. Invalid slots, and a withheld valid strobe carrying a live move, must leave the destination register unchanged. Any stray write shows up on a later readback.

// File: rtl/mvp_pkg.sv
package mvp_pkg;

   // endpoint address width and fixed endpoint codes
   localparam int EP_W = 5;
   localparam logic [EP_W-1:0] EP_OPND = 5'd8;
   localparam logic [EP_W-1:0] EP_RES  = 5'd9;
   localparam logic [EP_W-1:0] EP_LIT  = 5'd10;
   localparam logic [EP_W-1:0] EP_TRIG = 5'd16;
   localparam int NUM_OPS = 6;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_NAND = 3'd5
   } alu_op_e;

endpackage

// File: rtl/mvp_decoder.sv
module mvp_decoder
   import mvp_pkg::*;
#(
   parameter int W    = 16,
   parameter int NREG = 8,
   localparam int SLOT_W = 1 + 2*EP_W + W,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic              accept_i,
   output logic              slot_v_o,
   output logic [EP_W-1:0]   src_o,
   output logic [W-1:0]      lit_o,
   output logic              wr_reg_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic              wr_opnd_o,
   output logic              wr_trig_o,
   output alu_op_e           trig_op_o
);

   logic [EP_W-1:0] dst;
   logic [EP_W-1:0] trig_off;

   assign slot_v_o = accept_i & slot_i[SLOT_W-1];
   assign src_o    = slot_i[SLOT_W-2 -: EP_W];
   assign dst      = slot_i[SLOT_W-2-EP_W -: EP_W];
   assign lit_o    = slot_i[W-1:0];
   assign trig_off = dst - EP_TRIG;

   always_comb begin
      wr_reg_o  = slot_v_o && (int'(dst) < NREG);
      wr_idx_o  = dst[IDX_W-1:0];
      wr_opnd_o = slot_v_o && (dst == EP_OPND);
      wr_trig_o = slot_v_o && (dst >= EP_TRIG) && (int'(trig_off) < NUM_OPS);
      trig_op_o = alu_op_e'(trig_off[2:0]);
   end

   // a slot lands on at most one kind of destination (supports R9 merge)
   assert_one_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_reg_o, wr_opnd_o, wr_trig_o}));

endmodule

// File: rtl/mvp_regfile.sv
module mvp_regfile #(
   parameter int W    = 16,
   parameter int NREG = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NREG-1:0]           we_i,
   input  logic [NREG-1:0][W-1:0]    wd_i,
   output logic [NREG-1:0][W-1:0]    rd_o
);

   logic [NREG-1:0][W-1:0] regs;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)       regs[r] <= '0;
         else if (we_i[r]) regs[r] <= wd_i[r];
      end
   end

   assign rd_o = regs;

   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (regs == '0));

   assert_no_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i == '0) |=> $stable(regs));

endmodule

// File: rtl/mvp_alu_fu.sv
module mvp_alu_fu
   import mvp_pkg::*;
#(
   parameter int W   = 16,
   parameter int LAT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         opnd_we_i,
   input  logic [W-1:0] opnd_wd_i,
   input  logic         trig_we_i,
   input  logic [W-1:0] trig_wd_i,
   input  alu_op_e      trig_op_i,
   output logic [W-1:0] opnd_o,
   output logic [W-1:0] result_o
);

   if (LAT < 1) begin : g_bad_lat
      $error("mvp_alu_fu: LAT must be at least 1");
   end

   logic [W-1:0]           opnd_q;
   logic [W-1:0]           result_q;
   logic [W-1:0]           op1_next;
   logic [LAT-1:0]         pipe_v;
   logic [LAT-1:0][W-1:0]  pipe_d;

   function automatic logic [W-1:0] calc(alu_op_e op, logic [W-1:0] a, logic [W-1:0] b);
      case (op)
         OP_ADD:  return a + b;
         OP_SUB:  return a - b;
         OP_AND:  return a & b;
         OP_OR:   return a | b;
         OP_XOR:  return a ^ b;
         OP_NAND: return ~(a & b);
         default: return '0;
      endcase
   endfunction

   // a latch write in the same instruction as the trigger is seen by it
   assign op1_next = opnd_we_i ? opnd_wd_i : opnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opnd_q   <= '0;
         result_q <= '0;
         pipe_v   <= '0;
         pipe_d   <= '0;
      end else begin
         opnd_q    <= op1_next;
         pipe_v[0] <= trig_we_i;
         if (trig_we_i) pipe_d[0] <= calc(trig_op_i, op1_next, trig_wd_i);
         for (int i = 1; i < LAT; i++) begin
            pipe_v[i] <= pipe_v[i-1];
            pipe_d[i] <= pipe_d[i-1];
         end
         if (pipe_v[LAT-1]) result_q <= pipe_d[LAT-1];
      end
   end

   assign opnd_o   = opnd_q;
   assign result_o = result_q;

   assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_v[LAT-1] |=> $stable(result_q));

   assert_opnd_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !opnd_we_i |=> $stable(opnd_q));

   if (LAT == 1) begin : g_lat1_chk
      assert_add_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_we_i && trig_op_i == OP_ADD) |=> ##1
         (result_q == $past(op1_next + trig_wd_i, 2)));
   end

endmodule

// File: rtl/move_datapath.sv
module move_datapath
   import mvp_pkg::*;
#(
   parameter int W    = 16,
   parameter int NREG = 8,
   parameter int NBUS = 2,
   parameter int LAT  = 1,
   localparam int SLOT_W = 1 + 2*EP_W + W,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_valid_i,
   output logic                 instr_ready_o,
   input  logic [NBUS*SLOT_W-1:0] instr_i,
   output logic [NBUS-1:0]      bus_busy_o,
   output logic [NBUS*W-1:0]    bus_data_o,
   output logic [W-1:0]         fu_result_o
);

   if (NREG < 2 || NREG > int'(EP_OPND)) begin : g_bad_nreg
      $error("move_datapath: NREG must lie in 2..8");
   end
   if (NBUS < 1) begin : g_bad_nbus
      $error("move_datapath: NBUS must be at least 1");
   end

   logic                        ready_q;
   logic                        accept;
   logic [NBUS-1:0]             slot_v;
   logic [NBUS-1:0][EP_W-1:0]   src;
   logic [NBUS-1:0][W-1:0]      lit;
   logic [NBUS-1:0]             wr_reg;
   logic [NBUS-1:0][IDX_W-1:0]  wr_idx;
   logic [NBUS-1:0]             wr_opnd;
   logic [NBUS-1:0]             wr_trig;
   alu_op_e                     trig_op [NBUS];
   logic [NBUS-1:0][W-1:0]      bus_val;

   logic [NREG-1:0]             rf_we;
   logic [NREG-1:0][W-1:0]      rf_wd;
   logic [NREG-1:0][W-1:0]      rf_rd;
   logic                        opnd_we;
   logic [W-1:0]                opnd_wd;
   logic                        trig_we;
   logic [W-1:0]                trig_wd;
   alu_op_e                     trig_sel;
   logic [W-1:0]                opnd_q;
   logic [W-1:0]                result_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign instr_ready_o = ready_q;
   assign accept        = instr_valid_i & ready_q;

   for (genvar b = 0; b < NBUS; b++) begin : g_bus
      mvp_decoder #(.W(W), .NREG(NREG)) u_dec (
         .clk       (clk),
         .rst_n     (rst_n),
         .slot_i    (instr_i[b*SLOT_W +: SLOT_W]),
         .accept_i  (accept),
         .slot_v_o  (slot_v[b]),
         .src_o     (src[b]),
         .lit_o     (lit[b]),
         .wr_reg_o  (wr_reg[b]),
         .wr_idx_o  (wr_idx[b]),
         .wr_opnd_o (wr_opnd[b]),
         .wr_trig_o (wr_trig[b]),
         .trig_op_o (trig_op[b])
      );
   end

   // source side: every bus reads pre-instruction state
   always_comb begin
      for (int b = 0; b < NBUS; b++) begin
         bus_val[b] = '0;
         if (slot_v[b]) begin
            if (int'(src[b]) < NREG)  bus_val[b] = rf_rd[src[b][IDX_W-1:0]];
            else if (src[b] == EP_OPND) bus_val[b] = opnd_q;
            else if (src[b] == EP_RES)  bus_val[b] = result_q;
            else if (src[b] == EP_LIT)  bus_val[b] = lit[b];
         end
      end
   end

   // destination side: ascending scan so the highest bus wins
   always_comb begin
      rf_we    = '0;
      rf_wd    = '0;
      opnd_we  = 1'b0;
      opnd_wd  = '0;
      trig_we  = 1'b0;
      trig_wd  = '0;
      trig_sel = OP_ADD;
      for (int b = 0; b < NBUS; b++) begin
         if (wr_reg[b]) begin
            rf_we[wr_idx[b]] = 1'b1;
            rf_wd[wr_idx[b]] = bus_val[b];
         end
         if (wr_opnd[b]) begin
            opnd_we = 1'b1;
            opnd_wd = bus_val[b];
         end
         if (wr_trig[b]) begin
            trig_we  = 1'b1;
            trig_wd  = bus_val[b];
            trig_sel = trig_op[b];
         end
      end
   end

   mvp_regfile #(.W(W), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (rf_we),
      .wd_i  (rf_wd),
      .rd_o  (rf_rd)
   );

   mvp_alu_fu #(.W(W), .LAT(LAT)) u_alu (
      .clk       (clk),
      .rst_n     (rst_n),
      .opnd_we_i (opnd_we),
      .opnd_wd_i (opnd_wd),
      .trig_we_i (trig_we),
      .trig_wd_i (trig_wd),
      .trig_op_i (trig_sel),
      .opnd_o    (opnd_q),
      .result_o  (result_q)
   );

   assign bus_busy_o  = slot_v;
   assign bus_data_o  = bus_val;
   assign fu_result_o = result_q;

   assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> instr_ready_o);

endmodule

// File: tb/sim_move_datapath.sv
module sim_move_datapath;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 27;

   // endpoint codes as the requirements state them
   localparam logic [4:0] E_OP = 5'd8,  E_RS = 5'd9,  E_IM = 5'd10;
   localparam logic [4:0] T_ADD = 5'd16, T_SUB = 5'd17, T_AND = 5'd18;
   localparam logic [4:0] T_OR = 5'd19, T_XOR = 5'd20, T_NAND = 5'd21;

   typedef struct packed {
      logic [2*SW-1:0] ins;
      logic [15:0]     e0;
      logic [15:0]     e1;
      logic [15:0]     er;
      logic [2:0]      msk;
      logic [7:0]      tag;
   } vec_t;

   function automatic logic [SW-1:0] sl(logic v, logic [4:0] s, logic [4:0] d, logic [15:0] k);
      return {v, s, d, k};
   endfunction

   function automatic vec_t mv(logic [SW-1:0] s0, logic [SW-1:0] s1, logic [15:0] e0,
                               logic [15:0] e1, logic [15:0] er, logic [2:0] m, int t);
      return '{ins: {s1, s0}, e0: e0, e1: e1, er: er, msk: m, tag: 8'(t)};
   endfunction

   localparam logic [SW-1:0] NOP = '0;
   localparam int NV = 32;
   // msk bit0: bus0, bit1: bus1, bit2: result port
   localparam vec_t VEC [NV] = '{
      mv(sl(1,0,0,0),          sl(1,7,7,0),           16'h0000,16'h0000,16'h0000,3'b111,1),  // R1
      mv(sl(1,E_IM,1,'h1234),  sl(1,E_IM,2,'h00F0),   16'h1234,16'h00F0,16'h0000,3'b111,7),  // R7
      mv(sl(1,1,1,0),          sl(1,2,2,0),           16'h1234,16'h00F0,16'h0000,3'b011,2),  // R2
      mv(sl(1,1,E_OP,0),       sl(1,2,T_ADD,0),       16'h1234,16'h00F0,16'h0000,3'b111,3),  // R3
      mv(sl(1,E_RS,3,0),       sl(1,E_RS,4,0),        16'h0000,16'h0000,16'h0000,3'b111,5),  // R5
      mv(sl(1,E_RS,3,0),       NOP,                   16'h1324,16'h0000,16'h1324,3'b111,5),  // R5
      mv(sl(1,3,3,0),          sl(1,4,4,0),           16'h1324,16'h0000,16'h1324,3'b011,5),  // R5
      mv(sl(1,2,T_SUB,0),      NOP,                   16'h00F0,16'h0000,16'h0000,3'b001,6),  // R6
      mv(NOP,                  NOP,                   16'h0000,16'h0000,16'h1324,3'b111,10), // R10
      mv(sl(1,E_RS,5,0),       NOP,                   16'h1144,16'h0000,16'h1144,3'b101,6),  // R6
      mv(sl(1,E_IM,E_OP,'h00FF), sl(1,E_IM,T_AND,'h0F0F), 16'h00FF,16'h0F0F,16'h1144,3'b111,4), // R4
      mv(NOP,                  NOP,                   16'h0000,16'h0000,16'h1144,3'b100,5),  // R5
      mv(sl(1,E_RS,6,0),       NOP,                   16'h000F,16'h0000,16'h000F,3'b101,4),  // R4
      mv(NOP,                  sl(1,E_IM,T_OR,'h0F0F),16'h0000,16'h0F0F,16'h0000,3'b010,4),  // R4
      mv(NOP,                  NOP,                   16'h0000,16'h0000,16'h000F,3'b100,5),  // R5
      mv(sl(1,E_RS,0,0),       NOP,                   16'h0FFF,16'h0000,16'h0FFF,3'b101,4),  // R4
      mv(NOP,                  sl(1,E_IM,T_XOR,'h0F0F),16'h0000,16'h0F0F,16'h0000,3'b010,4), // R4
      mv(NOP,                  NOP,                   16'h0000,16'h0000,16'h0000,3'b000,4),
      mv(sl(1,E_RS,6,0),       NOP,                   16'h0FF0,16'h0000,16'h0FF0,3'b101,4),  // R4
      mv(NOP,                  sl(1,E_IM,T_NAND,'h0F0F),16'h0000,16'h0F0F,16'h0000,3'b010,4), // R4
      mv(NOP,                  NOP,                   16'h0000,16'h0000,16'h0000,3'b000,4),
      mv(sl(1,E_RS,6,0),       NOP,                   16'hFFF0,16'h0000,16'hFFF0,3'b101,4),  // R4
      mv(sl(1,E_IM,E_OP,'h0003), sl(1,E_IM,T_SUB,'h0005), 16'h0003,16'h0005,16'hFFF0,3'b111,6), // R6
      mv(NOP,                  NOP,                   16'h0000,16'h0000,16'h0000,3'b000,6),
      mv(sl(1,E_RS,6,0),       NOP,                   16'hFFFE,16'h0000,16'hFFFE,3'b101,6),  // R6
      mv(sl(1,1,2,0),          sl(1,2,1,0),           16'h1234,16'h00F0,16'h0000,3'b011,8),  // R8
      mv(sl(1,1,1,0),          sl(1,2,2,0),           16'h00F0,16'h1234,16'h0000,3'b011,8),  // R8
      mv(sl(1,E_IM,7,'hAAAA),  sl(1,E_IM,7,'h5555),   16'hAAAA,16'h5555,16'h0000,3'b011,9),  // R9
      mv(sl(1,7,7,0),          NOP,                   16'h5555,16'h0000,16'h0000,3'b001,9),  // R9
      mv(sl(0,E_IM,7,'h9999),  sl(0,E_IM,5,'h1111),   16'h0000,16'h0000,16'h0000,3'b011,10), // R10
      mv(sl(1,7,7,0),          sl(1,5,5,0),           16'h5555,16'h1144,16'h0000,3'b011,10), // R10
      mv(sl(1,0,0,0),          sl(1,3,3,0),           16'h0FFF,16'h1324,16'h0000,3'b011,2)   // R2
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [2*SW-1:0] instr = '0;
   logic            ready;
   logic [1:0]      busy;
   logic [31:0]     bus_data;
   logic [15:0]     result;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   move_datapath u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .instr_valid_i (instr_valid),
      .instr_ready_o (ready),
      .instr_i       (instr),
      .bus_busy_o    (busy),
      .bus_data_o    (bus_data),
      .fu_result_o   (result)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 ready low in reset", 16'(ready), 16'h0);
      check("R1 result zero in reset", result, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1 ready after reset", 16'(ready), 16'h1);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         instr_valid = 1'b1;
         instr       = VEC[i].ins;
         #1;
         if (VEC[i].msk[0]) check($sformatf("R%0d vec %0d bus0", VEC[i].tag, i), bus_data[15:0], VEC[i].e0);
         if (VEC[i].msk[1]) check($sformatf("R%0d vec %0d bus1", VEC[i].tag, i), bus_data[31:16], VEC[i].e1);
         if (VEC[i].msk[2]) check($sformatf("R%0d vec %0d result", VEC[i].tag, i), result, VEC[i].er);
      end

      // R10: a live move withheld by instr_valid low must not land
      @(negedge clk);
      instr_valid = 1'b0;
      instr       = {NOP, sl(1, E_IM, 5, 16'h7777)};
      #1;
      check("R10 idle bus flags", 16'(busy), 16'h0);
      check("R10 idle bus data", bus_data[15:0], 16'h0);
      @(negedge clk);
      @(negedge clk);
      instr_valid = 1'b1;
      instr       = {NOP, sl(1, 5, 5, 0)};
      #1;
      check("R10 r5 untouched", bus_data[15:0], 16'h1144);
      check("R7 busy flag bus0 only", 16'(busy), 16'h1);

      // R1: reset mid-run clears state
      @(negedge clk);
      instr_valid = 1'b0;
      rst_n       = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      instr_valid = 1'b1;
      instr       = {sl(1, E_OP, E_OP, 0), sl(1, 1, 1, 0)};
      #1;
      check("R1 r1 cleared", bus_data[15:0], 16'h0);
      check("R1 operand cleared", bus_data[31:16], 16'h0);
      check("R1 result cleared", result, 16'h0);
      @(negedge clk);
      instr_valid = 1'b0;
      finished = 1'b1;
      summary();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule